// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. A request carries the address, a three-bit mask of the access wanted (read, write, execute), a privilege mode index, a flag that selects untranslated physical access, and the base of the top-level page table. Some requests resolve without touching memory: physical-bypass requests, addresses that are not properly sign-extended, and addresses in a direct-mapped kernel window. Every other address is resolved by reading up to three 64-bit page table entries through a single-outstanding request/response memory port.

The result is a physical address, the three permission bits that were granted, and a fault code. The page offset is 13 bits, giving 8 KiB pages. Each table level is indexed by 10 bits of the address and holds 8-byte entries. The walker accepts a request only when it is idle. It holds `busy` high while it walks and marks the result with a single-cycle `done` pulse. There is no translation cache, and the memory port has no error path.

Top module: `pt_walker`

## Requirements
- R1: During and directly after reset, `busy`, `done` and `mem_req_valid` are low and `fault_code` is 0.
- R2: A request accepted with `req_phys` high completes with `done` on the next cycle, with `paddr` equal to `req_vaddr`, `prot` = 3'b111 (bit 0 read, bit 1 write, bit 2 exec), `fault_code` 0 and no memory read.
- R3: Fault codes are 0 none, 1 access violation, 2 translation not valid, 3 fault-on-read, 4 fault-on-write, 5 fault-on-execute. If address bits 63:43 are not all equal, the result is code 1 on the next cycle with no memory read.
- R4: A sign-correct address with bit 63 set and bits 42:41 = 2'b10, taken in mode 0, completes on the next cycle. Its `paddr` holds address bits 39:0 in place, address bit 40 at bit 43 and zeros elsewhere, with `prot` = 3'b111 and no memory read.
- R5: The same window reached in any mode other than 0 gives code 1 on the next cycle.
- R6: Any other address is walked with exactly one read per level reached. The level-1 entry is at table base + 8 * address bits 42:33, level 2 uses bits 32:23 and level 3 uses bits 22:13. The next base is entry bits 63:32 shifted left by 13.
- R7: An entry with bit 0 (valid) clear at any level ends the walk with code 2 and no further reads.
- R8: A level-1 or level-2 entry that is valid but has bit 8 (kernel read) clear ends the walk with code 1.
- R9: In the leaf entry, bit 8+mode grants read and execute and bit 12+mode grants write. On success, `paddr` = (entry bits 63:32 << 13) | address bits 12:0.
- R10: A nonzero access mask that shares no bit with the leaf grants gives code 1.
- R11: Leaf bits 1, 2 and 3 clear the granted read, write and execute bits. If the nonzero mask then shares no bit with what is left, the code is 5 when execute was asked, otherwise 4 when write was asked, otherwise 3. On success `prot` reports the reduced grants.
- R12: `busy` is high from the cycle after acceptance until the result. `done` is a single-cycle pulse one cycle after the final response is sampled. Each level issues a one-cycle `mem_req_valid` pulse.
- R13: Whenever `fault_code` is nonzero at `done`, `paddr` and `prot` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 3 | Access mask: bit 0 read, bit 1 write, bit 2 execute |
| req_mode | input | 2 | Privilege mode index, 0 is kernel |
| req_phys | input | 1 | Physical bypass request |
| ptbr | input | 64 | Level-1 table base byte address |
| mem_req_valid | output | 1 | One-cycle read request pulse |
| mem_req_addr | output | 64 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid, at least one cycle after the request |
| mem_rsp_data | input | 64 | Page table entry |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid for this cycle |
| paddr | output | 64 | Physical address |
| prot | output | 3 | Granted permissions |
| fault_code | output | 3 | Fault code, 0 for success |

## Verification
Fast-path results (bypass, bad sign, kernel window) are due in the cycle after the accepting edge. A walk result is due in the cycle after the edge that samples the last response. Each memory request appears in the cycle after acceptance or after the previous response. The bench drives and samples on falling edges. It checks every request address as it appears against a queue that its own walk model fills, and it requires `busy` on each cycle until `done`. It then compares the result in the single cycle where `done` is high and confirms that `done` has dropped one cycle later. Memory latency is varied between tests so the per-cycle timing is not tuned to a single delay.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1   = 3'd1,
        ST_L2   = 3'd2,
        ST_L3   = 3'd3,
        ST_DONE = 3'd4
    } walk_st_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } flt_e;

    localparam int PTE_VALID   = 0;
    localparam int PTE_FO_LO   = 1;
    localparam int PTE_RD_BASE = 8;
    localparam int PTE_WR_BASE = 12;
    localparam int PTE_FRAME_LO = 32;
endpackage

// File: rtl/ptw_front.sv
module ptw_front
    import ptw_pkg::*;
#(
    parameter int VA_BITS = 43,
    parameter int SP_KEEP = 40,
    parameter int SP_DEST = 43,
    parameter int MODE_W  = 2
) (
    input  logic [63:0]       vaddr,
    input  logic              phys,
    input  logic [MODE_W-1:0] mode,
    output logic              fast,
    output logic [63:0]       fast_pa,
    output logic [2:0]        fast_prot,
    output flt_e              fast_code
);
    localparam int HI_W = 64 - VA_BITS;

    logic sext_ok;
    logic in_window;

    assign sext_ok   = (vaddr[63:VA_BITS] == {HI_W{vaddr[63]}});
    assign in_window = vaddr[63] && (vaddr[VA_BITS-1:VA_BITS-2] == 2'b10);

    always_comb begin
        fast      = 1'b0;
        fast_pa   = '0;
        fast_prot = '0;
        fast_code = FLT_NONE;
        if (phys) begin
            fast      = 1'b1;
            fast_pa   = vaddr;
            fast_prot = 3'b111;
        end else if (!sext_ok) begin
            fast      = 1'b1;
            fast_code = FLT_ACV;
        end else if (in_window) begin
            fast = 1'b1;
            if (mode != '0) begin
                fast_code = FLT_ACV;
            end else begin
                fast_pa   = 64'(vaddr[SP_KEEP-1:0]) | (64'(vaddr[SP_KEEP]) << SP_DEST);
                fast_prot = 3'b111;
            end
        end
    end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
    import ptw_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int MODE_W    = 2
) (
    input  logic [63:0]          pte,
    input  logic [2:0]           acc,
    input  logic [MODE_W-1:0]    mode,
    input  logic [PAGE_BITS-1:0] off,
    output logic [63:0]          leaf_pa,
    output logic [2:0]           leaf_prot,
    output flt_e                 leaf_code
);
    logic       rd_en;
    logic       wr_en;
    logic [2:0] grant;
    logic [2:0] kept;
    logic [63:0] frame_pa;

    assign rd_en    = pte[PTE_RD_BASE + int'(mode)];
    assign wr_en    = pte[PTE_WR_BASE + int'(mode)];
    assign grant    = {rd_en, wr_en, rd_en};
    assign kept     = grant & ~pte[PTE_FO_LO +: 3];
    assign frame_pa = (64'(pte[63:PTE_FRAME_LO]) << PAGE_BITS) | 64'(off);

    always_comb begin
        leaf_code = FLT_NONE;
        if (acc != 3'b000 && (grant & acc) == 3'b000) begin
            leaf_code = FLT_ACV;
        end else if (acc != 3'b000 && (kept & acc) == 3'b000) begin
            if (acc[2])      leaf_code = FLT_FOE;
            else if (acc[1]) leaf_code = FLT_FOW;
            else             leaf_code = FLT_FOR;
        end
        leaf_pa   = (leaf_code == FLT_NONE) ? frame_pa : '0;
        leaf_prot = (leaf_code == FLT_NONE) ? kept : '0;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS   = 43,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int MODE_W    = 2,
    parameter int SP_KEEP   = 40,
    parameter int SP_DEST   = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       req_vaddr,
    input  logic [2:0]        req_acc,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_phys,
    input  logic [63:0]       ptbr,
    output logic              mem_req_valid,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              busy,
    output logic              done,
    output logic [63:0]       paddr,
    output logic [2:0]        prot,
    output logic [2:0]        fault_code
);
    localparam int SH_L3 = PAGE_BITS;
    localparam int SH_L2 = PAGE_BITS + IDX_BITS;
    localparam int SH_L1 = PAGE_BITS + 2 * IDX_BITS;
    localparam int ENTRY_SH = 3;

    typedef struct packed {
        walk_st_e             st;
        logic                 issued;
        logic [VA_BITS-1:0]   va;
        logic [2:0]           acc;
        logic [MODE_W-1:0]    mode;
        logic [63:0]          base;
        logic [63:0]          pa;
        logic [2:0]           prot;
        flt_e                 code;
    } wstate_t;

    wstate_t r_q, r_d;

    logic              fast;
    logic [63:0]       fast_pa;
    logic [2:0]        fast_prot;
    flt_e              fast_code;
    logic [63:0]       leaf_pa;
    logic [2:0]        leaf_prot;
    flt_e              leaf_code;
    logic [IDX_BITS-1:0] lvl_idx;
    logic              accept;
    logic              rsp_take;

    ptw_front #(
        .VA_BITS(VA_BITS), .SP_KEEP(SP_KEEP), .SP_DEST(SP_DEST), .MODE_W(MODE_W)
    ) u_front (
        .vaddr(req_vaddr), .phys(req_phys), .mode(req_mode),
        .fast(fast), .fast_pa(fast_pa), .fast_prot(fast_prot), .fast_code(fast_code)
    );

    ptw_leaf #(
        .PAGE_BITS(PAGE_BITS), .MODE_W(MODE_W)
    ) u_leaf (
        .pte(mem_rsp_data), .acc(r_q.acc), .mode(r_q.mode), .off(r_q.va[PAGE_BITS-1:0]),
        .leaf_pa(leaf_pa), .leaf_prot(leaf_prot), .leaf_code(leaf_code)
    );

    always_comb begin
        case (r_q.st)
            ST_L1:   lvl_idx = r_q.va[SH_L1 +: IDX_BITS];
            ST_L2:   lvl_idx = r_q.va[SH_L2 +: IDX_BITS];
            default: lvl_idx = r_q.va[SH_L3 +: IDX_BITS];
        endcase
    end

    assign busy          = (r_q.st == ST_L1) || (r_q.st == ST_L2) || (r_q.st == ST_L3);
    assign done          = (r_q.st == ST_DONE);
    assign mem_req_valid = busy && !r_q.issued;
    assign mem_req_addr  = r_q.base + (64'(lvl_idx) << ENTRY_SH);
    assign paddr         = r_q.pa;
    assign prot          = r_q.prot;
    assign fault_code    = r_q.code;
    assign accept        = (r_q.st == ST_IDLE) && req_valid;
    assign rsp_take      = busy && r_q.issued && mem_rsp_valid;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va     = req_vaddr[VA_BITS-1:0];
                    r_d.acc    = req_acc;
                    r_d.mode   = req_mode;
                    r_d.issued = 1'b0;
                    r_d.base   = ptbr;
                    r_d.pa     = fast_pa;
                    r_d.prot   = fast_prot;
                    r_d.code   = fast_code;
                    r_d.st     = fast ? ST_DONE : ST_L1;
                end
            end
            ST_L1, ST_L2, ST_L3: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (mem_rsp_valid) begin
                    r_d.issued = 1'b0;
                    if (!mem_rsp_data[PTE_VALID]) begin
                        r_d.code = FLT_TNV;
                        r_d.pa   = '0;
                        r_d.prot = '0;
                        r_d.st   = ST_DONE;
                    end else if (r_q.st == ST_L3) begin
                        r_d.code = leaf_code;
                        r_d.pa   = leaf_pa;
                        r_d.prot = leaf_prot;
                        r_d.st   = ST_DONE;
                    end else if (!mem_rsp_data[PTE_RD_BASE]) begin
                        r_d.code = FLT_ACV;
                        r_d.pa   = '0;
                        r_d.prot = '0;
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.base = 64'(mem_rsp_data[63:PTE_FRAME_LO]) << PAGE_BITS;
                        r_d.st   = (r_q.st == ST_L1) ? ST_L2 : ST_L3;
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2
    phys_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_phys) |=> (done && paddr == $past(req_vaddr) && prot == 3'b111 && fault_code == 3'd0));

    // R5
    kseg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_phys && (&req_vaddr[63:VA_BITS]) && req_vaddr[VA_BITS-1:VA_BITS-2] == 2'b10 && req_mode != '0)
        |=> (done && fault_code == 3'd1));

    // R7
    invalid_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && !mem_rsp_data[PTE_VALID]) |=> (done && fault_code == 3'd2));

    // R11
    grant_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code == 3'd0 && r_q.acc != 3'b000) |-> ((prot & r_q.acc) != 3'b000));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R13
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 3'd0) |-> (paddr == 64'd0 && prot == 3'b000));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [2:0]  req_acc;
    logic [1:0]  req_mode;
    logic        req_phys;
    logic [63:0] ptbr;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        busy;
    logic        done;
    logic [63:0] paddr;
    logic [2:0]  prot;
    logic [2:0]  fault_code;

    int total = 0;
    int bad   = 0;
    int lat   = 1;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];
    logic [63:0] pend_addr;
    logic [63:0] exp_addr;
    logic        pend;
    int          cnt;

    localparam logic [63:0] PT_BASE = 64'h0010_0000;

    always #5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_mode(req_mode), .req_phys(req_phys), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(done), .paddr(paddr), .prot(prot), .fault_code(fault_code)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] mk_va(input int i1, input int i2, input int i3, input int off);
        return (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'(off);
    endfunction

    // behavioural model of the whole translation; fills exp_q with reads
    task automatic model(input logic [63:0] va, input logic [2:0] acc, input int mode,
                         input bit phys, output logic [63:0] pa, output logic [2:0] pr,
                         output int code);
        logic [63:0] tb;
        logic [63:0] pte;
        logic [63:0] a;
        logic [2:0]  g;
        logic [2:0]  m;
        pa = 0; pr = 0; code = 0;
        if (phys) begin
            pa = va; pr = 3'b111; return;
        end
        if (va[63:43] != {21{va[63]}}) begin code = 1; return; end
        if (va[63] && va[42:41] == 2'b10) begin
            if (mode != 0) begin code = 1; return; end
            pa = (64'(va[40]) << 43) | (va & ((64'd1 << 40) - 1));
            pr = 3'b111;
            return;
        end
        tb = PT_BASE;
        for (int lvl = 0; lvl < 3; lvl++) begin
            a = tb + (((va >> (13 + 10 * (2 - lvl))) & 64'd1023) * 8);
            exp_q.push_back(a);
            pte = rd(a);
            if (pte[0] == 1'b0) begin code = 2; return; end
            if (lvl < 2) begin
                if (pte[8] == 1'b0) begin code = 1; return; end
                tb = 64'(pte[63:32]) * 64'd8192;
            end else begin
                g = {pte[8 + mode], pte[12 + mode], pte[8 + mode]};
                if (acc != 0 && (g & acc) == 0) begin code = 1; return; end
                m = g & ~pte[3:1];
                if (acc != 0 && (m & acc) == 0) begin
                    code = acc[2] ? 5 : (acc[1] ? 4 : 3);
                    return;
                end
                pa = 64'(pte[63:32]) * 64'd8192 + 64'(va[12:0]);
                pr = m;
            end
        end
    endtask

    task automatic run(input logic [63:0] va, input logic [2:0] acc, input int mode,
                       input bit phys, input string tag);
        logic [63:0] epa;
        logic [2:0]  epr;
        int          ecode;
        int          n;
        model(va, acc, mode, phys, epa, epr, ecode);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        req_mode = 2'(mode); req_phys = phys;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            chk(busy == 1'b1, {"R12 busy during walk ", tag}, 64'(busy), 64'd1);
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, {"R12 done arrives ", tag}, 64'(done), 64'd1);
        chk(fault_code == 3'(ecode), {"fault code ", tag}, 64'(fault_code), 64'(ecode));
        chk(paddr == epa, {"paddr ", tag}, paddr, epa);
        chk(prot == epr, {"prot ", tag}, 64'(prot), 64'(epr));
        chk(exp_q.size() == 0, {"R6 read count ", tag}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {"R12 single done pulse ", tag}, 64'(done), 64'd0);
    endtask

    // memory responder
    initial begin
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; pend = 1'b0; cnt = 0; pend_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pend_addr);
                    pend = 1'b0;
                end
            end
            if (mem_req_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected read", mem_req_addr, 64'd0);
                end else begin
                    exp_addr = exp_q.pop_front();
                    chk(mem_req_addr == exp_addr, "R6 read address", mem_req_addr, exp_addr);
                end
                pend = 1'b1; cnt = lat; pend_addr = mem_req_addr;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R12 watchdog act=%h exp=%h", 64'd1, 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0;
        req_mode = '0; req_phys = 1'b0; ptbr = PT_BASE;

        // tables: L1 -> frame 0x100, L2 -> frame 0x200
        mem[PT_BASE + 5 * 8]              = {32'h100, 32'h0000_0101};
        mem[64'h20_0000 + 7 * 8]          = {32'h200, 32'h0000_0101};
        mem[64'h20_0000 + 8 * 8]          = {32'h300, 32'h0000_0001};
        mem[64'h40_0000 + 9 * 8]          = {32'h3AB, 32'h0000_1301};
        mem[64'h40_0000 + 10 * 8]         = {32'h3AC, 32'h0000_110F};
        mem[64'h40_0000 + 11 * 8]         = {32'h3AD, 32'h0000_1105};

        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req_valid == 0, "R1 reset outputs", {61'd0, busy, done, mem_req_valid}, 64'd0);
        chk(fault_code == 3'd0, "R1 reset fault code", 64'(fault_code), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req_valid == 0, "R1 after reset", {61'd0, busy, done, mem_req_valid}, 64'd0);

        run(64'h1234_5678_9ABC_DEF0, 3'b010, 1, 1'b1, "R2 bypass");
        run(64'h0000_1000_0000_0000, 3'b001, 0, 1'b0, "R3 bad sign high");
        run(64'hFFFF_F000_0000_0000, 3'b001, 0, 1'b0, "R3 bad sign bit43");
        run(64'hFFFF_FD12_3456_789A, 3'b100, 0, 1'b0, "R4 kernel window");
        run(64'hFFFF_FC00_0000_0042, 3'b001, 0, 1'b0, "R4 kernel window bit40 clear");
        run(64'hFFFF_FD12_3456_789A, 3'b001, 1, 1'b0, "R5 window user mode");
        lat = 1;
        run(mk_va(5, 7, 9, 12'h123), 3'b001, 0, 1'b0, "R9 R6 kernel read walk");
        lat = 3;
        run(mk_va(5, 7, 9, 12'h456), 3'b010, 1, 1'b0, "R10 user write denied");
        run(mk_va(5, 7, 9, 12'h789), 3'b100, 1, 1'b0, "R9 user exec grant");
        lat = 2;
        run(mk_va(5, 7, 10, 0), 3'b100, 0, 1'b0, "R11 fault on exec");
        run(mk_va(5, 7, 10, 0), 3'b011, 0, 1'b0, "R11 write before read");
        run(mk_va(5, 7, 10, 0), 3'b001, 0, 1'b0, "R11 fault on read");
        run(mk_va(5, 7, 11, 5), 3'b010, 0, 1'b0, "R11 fault on write only");
        run(mk_va(5, 7, 11, 5), 3'b001, 0, 1'b0, "R11 reduced grant read");
        run(mk_va(5, 7, 9, 0), 3'b000, 1, 1'b0, "R9 empty mask");
        lat = 1;
        run(mk_va(6, 0, 0, 0), 3'b001, 0, 1'b0, "R7 level1 invalid");
        run(mk_va(5, 8, 0, 0), 3'b001, 0, 1'b0, "R8 level2 no kernel read");
        run(mk_va(5, 7, 12, 0), 3'b001, 0, 1'b0, "R7 R13 level3 invalid");
        run(64'hFFFF_F800_0000_0000 | mk_va(1023, 0, 0, 0), 3'b001, 0, 1'b0, "R6 negative walked address");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule